// File: doc/BRIEF.md
# Operand Transfer Sequencer with Auto-Update

This block carries out one operand load or store for an effective address that an address unit has already decoded. A command names the addressing form (register direct, immediate, absolute or register indirect), an optional pre-decrement or post-increment of the address register, a PC-relative flag, the operand size and the register number. The address unit supplies the offset (or the absolute address) and the PC base. The sequencer reads and writes the register file through one port and moves data over a 32-bit memory port. It ends each transfer with a one-cycle done pulse and a status code.

Some operands, such as 8- or 12-byte values, are transferred in several commands at one decoded address. For these the block keeps an accumulated displacement. Each transfer that does not update its register moves the next one further along. A transfer with an auto-update resets the displacement instead. A command flagged fresh clears the displacement at the start of a new instruction. Operands shorter than four bytes sit in the low-order bytes of the 32-bit register or of the data buses.

Top module: `otx_seq`

## Requirements
- R1: The auto-update step equals the operand length in bytes. The one exception is a 1-byte operand on register 15, the stack pointer, which steps by 2.
- R2: Pre-decrement (upd=1) in indirect mode forms the address as register minus step plus offset, ignoring the accumulated displacement. When the transfer completes, the register holds register minus step and the displacement is 0.
- R3: Post-increment (upd=2) in indirect mode forms the address as register plus offset plus displacement. After the access the register holds register plus step and the displacement is 0.
- R4: A register-direct transfer (mode=0) ends with status ILLEGAL when the operand is longer than 4 bytes or when the accumulated displacement is nonzero.
- R5: Operands shorter than 4 bytes use the low-order bytes. A direct load returns the low bytes of the register, zero-extended. A direct store replaces only the low bytes and keeps the upper bytes of the register.
- R6: A store in immediate mode (mode=1), or in indirect mode with the PC-relative flag set, ends with status ILLEGAL and writes neither the register file nor memory.
- R7: A PC-relative indirect load that also asks for an auto-update ends with status ILLEGAL.
- R8: Each successful transfer without an auto-update adds the operand length to the accumulated displacement. Indirect accesses (base plus offset) and absolute stores (mode=2) add the displacement to the address. Absolute loads do not add it.
- R9: A memory error ends the transfer with status FAULT. The address register is not written.
- R10: 1- and 2-byte operands take one memory beat, with byte lanes ordered little-endian by address bits [1:0]. Address bit 0 is ignored for 2-byte operands. Longer operands use full-word beats at address plus 4k, and the first beat carries the most significant word.
- R11: Size codes 0..4 select 1, 2, 4, 8 and 12 bytes; any other code is ILLEGAL. Status codes are 0 OK, 1 ILLEGAL, 2 FAULT. Done is a one-cycle pulse, two cycles after start when no memory beat is needed. The data inputs stay steady from start until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (taken when idle) |
| is_store | input | 1 | 1 = store, 0 = load |
| mode | input | 2 | 0 direct, 1 immediate, 2 absolute, 3 indirect |
| upd | input | 2 | 0 none, 1 pre-decrement, 2 post-increment |
| pc_rel | input | 1 | Indirect base is the PC value instead of the register |
| size | input | 3 | Operand size code |
| reg_num | input | 4 | Register number |
| fresh | input | 1 | Clear the accumulated displacement at start |
| ea_ofs | input | 32 | Offset from address unit, or absolute address |
| pc_val | input | 32 | PC-relative base |
| opnd_in | input | 96 | Store data or immediate value, right-aligned |
| done | output | 1 | Transfer finished (one cycle) |
| status | output | 2 | Completion status |
| ld_data | output | 96 | Loaded operand, right-aligned |
| rf_addr | output | 4 | Register file address |
| rf_rdata | input | 32 | Register file read data |
| rf_we | output | 1 | Register file write enable |
| rf_wdata | output | 32 | Register file write data |
| mem_req | output | 1 | Memory beat request, held until ack or error |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Beat address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with ack |
| mem_ack | input | 1 | Beat completed |
| mem_err | input | 1 | Beat failed |

## Verification
The hardest case to reach from the ports is the accumulated displacement. It cannot be seen directly and only shows through the address of a later transfer. The stimulus therefore issues back-to-back commands without the fresh flag: two 8-byte indirect loads, two absolute loads and two absolute stores. It checks that the second indirect load and the second store land one operand further on, while the second absolute load returns the same words. A second direct access that follows a successful one exposes a nonzero displacement as ILLEGAL. A fault is forced by aiming a pre-decrement into an address range where the memory model answers with an error. The register read afterwards must still hold its old value.

// File: rtl/otx_pkg.sv
package otx_pkg;
  localparam int OPND_W = 96;
  localparam int WORD_W = 32;
  localparam int SP_REG = 15;

  typedef enum logic [1:0] {M_DIRECT, M_IMMED, M_ABS, M_INDIR} mode_e;
  typedef enum logic [1:0] {U_NONE, U_PRE, U_POST, U_RSVD} upd_e;
  typedef enum logic [1:0] {ST_OK, ST_ILL, ST_FAULT, ST_RSVD} stat_e;
  typedef enum logic [2:0] {S_IDLE, S_PREP, S_MEM, S_UPD, S_DONE} state_e;

  // operand length in bytes, 0 for an unknown code
  function automatic logic [3:0] len_of(input logic [2:0] code);
    case (code)
      3'd0: return 4'd1;
      3'd1: return 4'd2;
      3'd2: return 4'd4;
      3'd3: return 4'd8;
      3'd4: return 4'd12;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [3:0] step_of(input logic [3:0] len, input logic is_sp);
    return (len == 4'd1 && is_sp) ? 4'd2 : len;
  endfunction

  function automatic logic [WORD_W-1:0] mask32(input logic [3:0] len);
    if (len >= 4'd4) return '1;
    return (WORD_W'(1) << {len, 3'b000}) - WORD_W'(1);
  endfunction

  function automatic logic [OPND_W-1:0] mask96(input logic [3:0] len);
    logic [OPND_W-1:0] m;
    m = '1;
    return m >> (7'd96 - {len, 3'b000});
  endfunction

  function automatic logic [1:0] beats_of(input logic [3:0] len);
    return (len > 4'd4) ? len[3:2] : 2'd1;
  endfunction

  // word sent on a given beat: most significant word first
  function automatic logic [WORD_W-1:0] beat_word(input logic [OPND_W-1:0] opnd,
                                                   input logic [3:0] len,
                                                   input logic [1:0] beat);
    logic [6:0] sh;
    if (len <= 4'd4) return opnd[WORD_W-1:0];
    sh = {len, 3'b000} - {2'(beat + 2'd1), 5'b00000};
    return WORD_W'(opnd >> sh);
  endfunction
endpackage

// File: rtl/otx_addr_gen.sv
module otx_addr_gen
  import otx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 8
) (
  input  mode_e             mode,
  input  upd_e              upd,
  input  logic              pc_rel,
  input  logic              is_store,
  input  logic [ADDR_W-1:0] reg_val,
  input  logic [ADDR_W-1:0] pc_val,
  input  logic [ADDR_W-1:0] ofs,
  input  logic [DISP_W-1:0] disp,
  input  logic [3:0]        step,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] new_reg
);
  logic [ADDR_W-1:0] disp_x, step_x, base;

  assign disp_x = ADDR_W'(disp);
  assign step_x = ADDR_W'(step);
  assign base   = pc_rel ? pc_val : reg_val;

  always_comb begin
    if (mode == M_ABS)
      addr = ofs + (is_store ? disp_x : '0);
    else if (upd == U_PRE)
      addr = reg_val - step_x + ofs;
    else
      addr = base + ofs + disp_x;
  end

  assign new_reg = (upd == U_PRE) ? reg_val - step_x : reg_val + step_x;
endmodule

// File: rtl/otx_lane.sv
module otx_lane
  import otx_pkg::*;
(
  input  logic [3:0]        len,
  input  logic [1:0]        lane,
  input  logic [WORD_W-1:0] st_word,
  input  logic [WORD_W-1:0] rd_word,
  output logic [3:0]        be,
  output logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rd_out
);
  logic       short_op;
  logic [1:0] lane_eff;
  logic [4:0] sh;

  assign short_op = (len < 4'd4);
  assign lane_eff = (len == 4'd2) ? {lane[1], 1'b0} : lane;
  assign sh       = short_op ? {lane_eff, 3'b000} : 5'd0;

  always_comb begin
    if (!short_op)       be = 4'hF;
    else if (len == 4'd1) be = 4'b0001 << lane_eff;
    else                 be = 4'b0011 << lane_eff;
  end

  assign wdata  = (st_word & mask32(len)) << sh;
  assign rd_out = (rd_word >> sh) & mask32(len);
endmodule

// File: rtl/otx_seq.sv
module otx_seq
  import otx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 8,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_store,
  input  logic [1:0]        mode,
  input  logic [1:0]        upd,
  input  logic              pc_rel,
  input  logic [2:0]        size,
  input  logic [REG_AW-1:0] reg_num,
  input  logic              fresh,
  input  logic [ADDR_W-1:0] ea_ofs,
  input  logic [ADDR_W-1:0] pc_val,
  input  logic [95:0]       opnd_in,
  output logic              done,
  output logic [1:0]        status,
  output logic [95:0]       ld_data,
  output logic [REG_AW-1:0] rf_addr,
  input  logic [31:0]       rf_rdata,
  output logic              rf_we,
  output logic [31:0]       rf_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err
);
  localparam int BEAT_W = $clog2(OPND_W / WORD_W + 1);

  state_e              state;
  logic                cmd_st, cmd_pc;
  mode_e               cmd_mode;
  upd_e                cmd_upd;
  logic [2:0]          cmd_size;
  logic [REG_AW-1:0]   cmd_reg;
  logic [DISP_W-1:0]   tdisp_r;
  logic [ADDR_W-1:0]   addr_r, newreg_r, ag_addr, ag_new, beat_addr;
  logic [BEAT_W-1:0]   beat_r;
  logic [OPND_W-1:0]   acc_r, ld_r;
  stat_e               stat_r;

  // named internal events for the checker
  logic [3:0]  cur_len, step;
  logic        upd_any, illegal, idle, upd_fire, ill_evt, dir_wr;
  logic [31:0] lane_rd;

  assign cur_len = len_of(cmd_size);
  assign step    = step_of(cur_len, cmd_reg == REG_AW'(SP_REG));
  assign upd_any = (cmd_mode == M_INDIR) && (cmd_upd == U_PRE || cmd_upd == U_POST);
  assign illegal = (cur_len == 4'd0)
                 || (cmd_mode == M_DIRECT && (cur_len > 4'd4 || tdisp_r != '0))
                 || (cmd_st && (cmd_mode == M_IMMED || (cmd_mode == M_INDIR && cmd_pc)))
                 || (!cmd_st && cmd_mode == M_INDIR && cmd_pc && upd_any);
  assign idle     = (state == S_IDLE);
  assign ill_evt  = (state == S_PREP) && illegal;
  assign upd_fire = (state == S_UPD) && upd_any;
  assign dir_wr   = (state == S_PREP) && !illegal && cmd_mode == M_DIRECT && cmd_st;

  otx_addr_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_ag (
    .mode(cmd_mode), .upd(cmd_upd), .pc_rel(cmd_pc), .is_store(cmd_st),
    .reg_val(ADDR_W'(rf_rdata)), .pc_val(pc_val), .ofs(ea_ofs), .disp(tdisp_r),
    .step(step), .addr(ag_addr), .new_reg(ag_new)
  );

  assign beat_addr = addr_r + ADDR_W'({beat_r, 2'b00});

  otx_lane u_lane (
    .len(cur_len), .lane(beat_addr[1:0]),
    .st_word(beat_word(opnd_in, cur_len, 2'(beat_r))), .rd_word(mem_rdata),
    .be(mem_be), .wdata(mem_wdata), .rd_out(lane_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cmd_st   <= 1'b0;
      cmd_pc   <= 1'b0;
      cmd_mode <= M_DIRECT;
      cmd_upd  <= U_NONE;
      cmd_size <= '0;
      cmd_reg  <= '0;
      tdisp_r  <= '0;
      addr_r   <= '0;
      newreg_r <= '0;
      beat_r   <= '0;
      acc_r    <= '0;
      ld_r     <= '0;
      stat_r   <= ST_OK;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          cmd_st   <= is_store;
          cmd_pc   <= pc_rel;
          cmd_mode <= mode_e'(mode);
          cmd_upd  <= upd_e'(upd);
          cmd_size <= size;
          cmd_reg  <= reg_num;
          if (fresh) tdisp_r <= '0;
          state <= S_PREP;
        end
        S_PREP: begin
          if (illegal) begin
            stat_r <= ST_ILL;
            state  <= S_DONE;
          end else if (cmd_mode == M_DIRECT || cmd_mode == M_IMMED) begin
            if (!cmd_st)
              ld_r <= (cmd_mode == M_DIRECT) ? OPND_W'(rf_rdata & mask32(cur_len))
                                             : (opnd_in & mask96(cur_len));
            tdisp_r <= tdisp_r + DISP_W'(cur_len);
            stat_r  <= ST_OK;
            state   <= S_DONE;
          end else begin
            addr_r   <= ag_addr;
            newreg_r <= ag_new;
            beat_r   <= '0;
            acc_r    <= '0;
            state    <= S_MEM;
          end
        end
        S_MEM: begin
          if (mem_err) begin
            stat_r <= ST_FAULT;
            state  <= S_DONE;
          end else if (mem_ack) begin
            acc_r <= {acc_r[OPND_W-WORD_W-1:0], lane_rd};
            if (2'(beat_r) == beats_of(cur_len) - 2'd1) state <= S_UPD;
            else beat_r <= beat_r + 1'b1;
          end
        end
        S_UPD: begin
          if (!cmd_st) ld_r <= acc_r;
          tdisp_r <= upd_any ? '0 : tdisp_r + DISP_W'(cur_len);
          stat_r  <= ST_OK;
          state   <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign done      = (state == S_DONE);
  assign status    = stat_r;
  assign ld_data   = ld_r;
  assign rf_addr   = cmd_reg;
  assign rf_we     = dir_wr || upd_fire;
  assign rf_wdata  = dir_wr ? ((rf_rdata & ~mask32(cur_len)) | (opnd_in[31:0] & mask32(cur_len)))
                            : newreg_r[31:0];
  assign mem_req   = (state == S_MEM);
  assign mem_we    = cmd_st;
  assign mem_addr  = beat_addr;
endmodule

// File: rtl/otx_chk.sv
module otx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       is_store,
  input logic [1:0] mode,
  input logic       done,
  input logic [1:0] status,
  input logic       mem_req,
  input logic       mem_err,
  input logic       rf_we,
  input logic [3:0] mem_be,
  input logic [3:0] cur_len,
  input logic       idle,
  input logic       upd_fire
);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R6
  imm_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && idle && is_store && mode == 2'd1 |=> ##1 (done && status == 2'd1));
  // R9
  fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_err |=> (done && status == 2'd2 && !rf_we));
  // R10
  byte_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && cur_len == 4'd1 |-> $countones(mem_be) == 1);
  // R10
  long_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && cur_len > 4'd4 |-> mem_be == 4'hF);
  // R3
  upd_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_fire |=> (done && status == 2'd0));
  // R9
  excl_port_chk: assert property (@(posedge clk) disable iff (!rst_n) !(rf_we && mem_req));
endmodule

bind otx_seq otx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store), .mode(mode),
  .done(done), .status(status), .mem_req(mem_req), .mem_err(mem_err), .rf_we(rf_we),
  .mem_be(mem_be), .cur_len(cur_len), .idle(idle), .upd_fire(upd_fire)
);

// File: tb/tb_otx_seq.sv
module tb_otx_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 0, is_store = 0, pc_rel = 0, fresh = 0;
  logic [1:0]  mode = 0, upd = 0;
  logic [2:0]  size = 0;
  logic [3:0]  reg_num = 0;
  logic [31:0] ea_ofs = 0, pc_val = 32'h1000;
  logic [95:0] opnd_in = 0;
  logic        done, rf_we, mem_req, mem_we;
  logic [1:0]  status;
  logic [95:0] ld_data;
  logic [3:0]  rf_addr, mem_be;
  logic [31:0] rf_rdata, rf_wdata, mem_addr, mem_wdata, mem_rdata;
  logic        mem_ack, mem_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  otx_seq dut (.*);

  // register file and memory models
  logic [31:0] rfm [16];
  logic [31:0] mem [1024];
  logic        tb_we = 0;
  logic [3:0]  tb_wa = 0;
  logic [31:0] tb_wd = 0;
  logic [31:0] mrd = 0;
  logic        ack_q = 0, err_q = 0;

  function automatic logic [7:0] ib(input logic [31:0] b);
    return b[7:0] ^ 8'h5A;
  endfunction
  function automatic logic [31:0] bw(input logic [31:0] a);
    return {ib(a + 3), ib(a + 2), ib(a + 1), ib(a)};
  endfunction

  assign rf_rdata  = rfm[rf_addr];
  assign mem_rdata = mrd;
  assign mem_ack   = ack_q;
  assign mem_err   = err_q;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) rfm[i] <= '0;
      for (int i = 0; i < 1024; i++) mem[i] <= bw(32'(i) << 2);
      ack_q <= 0; err_q <= 0;
    end else begin
      if (rf_we) rfm[rf_addr] <= rf_wdata;
      else if (tb_we) rfm[tb_wa] <= tb_wd;
      ack_q <= 0; err_q <= 0;
      if (mem_req && !ack_q && !err_q) begin
        if (mem_addr[31:28] == 4'hF) err_q <= 1;
        else begin
          ack_q <= 1;
          mrd <= mem[mem_addr[11:2]];
          if (mem_we)
            for (int b = 0; b < 4; b++)
              if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        end
      end
    end
  end

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard
  logic [1:0]  q_st [$];
  logic [95:0] q_d [$];
  bit          q_cd [$];
  string       q_tag [$];

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q_st.size() == 0) chk(0, "R11 unexpected done", 96'(status), 0);
      else begin
        logic [1:0] es; logic [95:0] ed; bit cd; string tg;
        es = q_st.pop_front(); ed = q_d.pop_front(); cd = q_cd.pop_front(); tg = q_tag.pop_front();
        chk(status == es, {tg, " status"}, 96'(status), 96'(es));
        if (cd) chk(ld_data == ed, {tg, " data"}, ld_data, ed);
      end
    end
  end

  task automatic set_reg(input logic [3:0] n, input logic [31:0] v);
    @(negedge clk); tb_we = 1; tb_wa = n; tb_wd = v;
    @(negedge clk); tb_we = 0;
  endtask

  task automatic xfer(input string tag, input bit st, input logic [1:0] md, input logic [1:0] up,
                      input bit pc, input logic [2:0] sz, input logic [3:0] rn, input bit fr,
                      input logic [31:0] ofs, input logic [95:0] op,
                      input logic [1:0] es, input logic [95:0] ed, input bit cd);
    q_st.push_back(es); q_d.push_back(ed); q_cd.push_back(cd); q_tag.push_back(tag);
    @(negedge clk);
    start = 1; is_store = st; mode = md; upd = up; pc_rel = pc; size = sz;
    reg_num = rn; fresh = fr; ea_ofs = ofs; opnd_in = op;
    @(negedge clk);
    start = 0;
    do @(negedge clk); while (!done);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!done && !mem_req && !rf_we && status == 2'd0, "R11 reset state",
        {mem_req, rf_we, done, status}, 0);

    set_reg(3, 32'h1234_5678);
    xfer("R5 direct word load", 0, 0, 0, 0, 1, 3, 1, 0, 0, 0, 96'h5678, 1);
    xfer("R4 second direct access", 0, 0, 0, 0, 1, 3, 0, 0, 0, 1, 0, 0);
    xfer("R4 direct 8-byte", 0, 0, 0, 0, 3, 3, 1, 0, 0, 1, 0, 0);

    set_reg(4, 32'hAABB_CCDD);
    xfer("R5 direct byte store", 1, 0, 0, 0, 0, 4, 1, 0, 96'hFF11, 0, 0, 0);
    chk(rfm[4] == 32'hAABB_CC11, "R5 register upper bytes kept", 96'(rfm[4]), 96'hAABB_CC11);

    xfer("R5 immediate long", 0, 1, 0, 0, 2, 0, 1, 0, 96'h1111_2222_3333_4444_CAFE_F00D,
         0, 96'hCAFE_F00D, 1);
    xfer("R11 immediate 8-byte", 0, 1, 0, 0, 3, 0, 1, 0, 96'h1111_2222_3333_4444_CAFE_F00D,
         0, 96'h3333_4444_CAFE_F00D, 1);
    xfer("R6 store immediate", 1, 1, 0, 0, 2, 0, 1, 0, 0, 1, 0, 0);
    xfer("R6 store pc-relative", 1, 3, 0, 1, 2, 0, 1, 0, 0, 1, 0, 0);
    xfer("R7 load pc-rel postinc", 0, 3, 2, 1, 2, 0, 1, 0, 0, 1, 0, 0);
    xfer("R11 bad size code", 0, 3, 0, 0, 5, 0, 1, 0, 0, 1, 0, 0);

    set_reg(15, 32'h100);
    xfer("R3 sp byte postinc", 0, 3, 2, 0, 0, 15, 1, 0, 0, 0, 96'(ib(32'h100)), 1);
    chk(rfm[15] == 32'h102, "R1 sp byte step 2", 96'(rfm[15]), 96'h102);
    set_reg(14, 32'h101);
    xfer("R10 byte lane 1 load", 0, 3, 2, 0, 0, 14, 1, 0, 0, 0, 96'(ib(32'h101)), 1);
    chk(rfm[14] == 32'h102, "R1 non-sp byte step 1", 96'(rfm[14]), 96'h102);

    set_reg(10, 32'h200);
    xfer("R2 predec word", 0, 3, 1, 0, 1, 10, 1, 0, 0, 0,
         96'({ib(32'h1FF), ib(32'h1FE)}), 1);
    chk(rfm[10] == 32'h1FE, "R2 predec register", 96'(rfm[10]), 96'h1FE);
    xfer("R1 sp byte predec", 0, 3, 1, 0, 0, 15, 1, 0, 0, 0, 96'(ib(32'h100)), 1);
    chk(rfm[15] == 32'h100, "R1 sp predec by 2", 96'(rfm[15]), 96'h100);

    set_reg(9, 32'h300);
    xfer("R10 8-byte first", 0, 3, 0, 0, 3, 9, 1, 32'h10, 0, 0,
         96'({bw(32'h310), bw(32'h314)}), 1);
    xfer("R8 8-byte second", 0, 3, 0, 0, 3, 9, 0, 32'h10, 0, 0,
         96'({bw(32'h318), bw(32'h31C)}), 1);

    xfer("R10 abs 12-byte", 0, 2, 0, 0, 4, 0, 1, 32'h400, 0, 0,
         {bw(32'h400), bw(32'h404), bw(32'h408)}, 1);
    xfer("R8 abs load ignores disp", 0, 2, 0, 0, 4, 0, 0, 32'h400, 0, 0,
         {bw(32'h400), bw(32'h404), bw(32'h408)}, 1);

    xfer("R8 abs store first", 1, 2, 0, 0, 2, 0, 1, 32'h500, 96'hDEAD_BEEF, 0, 0, 0);
    xfer("R8 abs store second", 1, 2, 0, 0, 2, 0, 0, 32'h500, 96'h0123_4567, 0, 0, 0);
    chk(mem[32'h500 >> 2] == 32'hDEAD_BEEF, "R8 abs store word 0", 96'(mem[32'h500 >> 2]), 96'hDEAD_BEEF);
    chk(mem[32'h504 >> 2] == 32'h0123_4567, "R8 abs store at disp", 96'(mem[32'h504 >> 2]), 96'h0123_4567);

    set_reg(11, 32'hF000_0010);
    xfer("R9 fault", 0, 3, 1, 0, 2, 11, 1, 0, 0, 2, 0, 0);
    chk(rfm[11] == 32'hF000_0010, "R9 register unchanged", 96'(rfm[11]), 96'hF000_0010);

    set_reg(12, 32'h600);
    xfer("R3 word store postinc", 1, 3, 2, 0, 1, 12, 1, 0, 96'hBEEF, 0, 0, 0);
    chk(mem[32'h600 >> 2] == {ib(32'h603), ib(32'h602), 16'hBEEF}, "R10 half lanes",
        96'(mem[32'h600 >> 2]), 96'({ib(32'h603), ib(32'h602), 16'hBEEF}));
    chk(rfm[12] == 32'h602, "R3 register after store", 96'(rfm[12]), 96'h602);

    set_reg(13, 32'h703);
    xfer("R10 byte store lane 3", 1, 3, 0, 0, 0, 13, 1, 0, 96'h77, 0, 0, 0);
    chk(mem[32'h700 >> 2] == {8'h77, ib(32'h702), ib(32'h701), ib(32'h700)}, "R10 byte lane 3",
        96'(mem[32'h700 >> 2]), 96'({8'h77, ib(32'h702), ib(32'h701), ib(32'h700)}));

    repeat (3) @(negedge clk);
    chk(q_st.size() == 0, "R11 all transfers completed", 96'(q_st.size()), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule